// File: doc/BRIEF.md
# Dead-Aware Victim Selector with Bypass

This block keeps the replacement state of a set-associative last-level cache. Every line of every set holds a recency rank (0 is most recent, `NWAYS-1` is least recent) and one bit that says whether the line is expected to see no further use. The tag and data arrays sit outside the block. So does the predictor, which gives one prediction bit with each access.

Each access names a set and reports whether the tag lookup hit, and on a hit which way. On a hit the block makes that way the most recent. It also replaces the way's dead bit with the prediction that came with the access. On a miss whose incoming block is predicted dead, the block raises a bypass indication and leaves the set untouched. On any other miss it names a victim way. The victim is the lowest-numbered line marked dead if there is one, and otherwise the least recent line. The victim takes the most recent rank and the fill's prediction.

Both searches and the bypass decision are combinational from the addressed set's state. The result is valid in the cycle of the request, and the state update lands at the next clock edge. One request is handled per cycle.

Top module: `dvs_victim_select`

## Requirements
- R1: After reset, every set holds way w at recency rank w and all dead bits are clear, so the first non-dead miss to a set returns way `NWAYS-1`.
- R2: A hit (`acc_valid=1`, `acc_hit=1`) gives `fill_bypass=0` and `fill_valid=0` in that cycle. After the edge, the hit way holds rank 0.
- R3: A hit overwrites the dead bit of the hit way with `acc_dead_pred`. Setting the bit can make the way a victim later, and clearing it stops that.
- R4: A miss with `acc_dead_pred=1` gives `fill_bypass=1` and `fill_valid=0` in the same cycle, and changes no rank and no dead bit.
- R5: A miss with `acc_dead_pred=0` in a set that holds one or more lines with the dead bit set gives `fill_valid=1`, with `fill_way` equal to the lowest-numbered such way.
- R6: A miss with `acc_dead_pred=0` in a set with no dead line gives `fill_valid=1`, with `fill_way` equal to the way at rank `NWAYS-1`.
- R7: When a way is touched by a hit or a fill, it takes rank 0 and every way with a smaller rank moves up by one. All other ranks keep their values, and the fill loads the touched way's dead bit from `acc_dead_pred`.
- R8: A request reads and writes only the set named by `acc_set`. The state of every other set is unchanged.
- R9: With `acc_valid=0`, both `fill_bypass` and `fill_valid` are 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_set | input | SETW | Set addressed by the request |
| acc_hit | input | 1 | Tag lookup hit |
| acc_hit_way | input | WAYW | Way that hit (used when acc_hit=1) |
| acc_dead_pred | input | 1 | Predictor verdict for the accessing or incoming block |
| fill_bypass | output | 1 | Miss whose block must not be allocated |
| fill_valid | output | 1 | Miss that allocates; fill_way is meaningful |
| fill_way | output | WAYW | Chosen victim way |

## Verification
The hardest case to reach from the ports is a set in which several lines carry dead bits while the least recent line is clean. Here the lowest-numbered dead line must win over the least recent one, and the ranks above the victim must shift while the ranks below it stay put. The directed stimulus gets there by hitting selected ways with a dead prediction and then issuing clean misses. A long random phase then mixes hits, fills and bypasses across several sets while a rank-and-bit model in the bench predicts every victim.

// File: rtl/dvs_pkg.sv
`timescale 1ns/1ps
package dvs_pkg;
   typedef enum logic [1:0] {
      OUT_IDLE   = 2'd0,
      OUT_HIT    = 2'd1,
      OUT_FILL   = 2'd2,
      OUT_BYPASS = 2'd3
   } dvs_outcome_e;
endpackage

// File: rtl/dvs_first_set.sv
`timescale 1ns/1ps
// Finds the lowest-numbered set bit of a vector.
module dvs_first_set #(
   parameter int N = 16,
   parameter int W = 4
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end

   logic [N-1:0] below_mask;
   assign below_mask = ({{(N-1){1'b0}}, 1'b1} << idx) - {{(N-1){1'b0}}, 1'b1};

   // R5: the chosen way is dead and no lower way is dead
   always_comb begin
      if (found) begin
         a_r5_lowest_dead: assert (vec[idx] && ((vec & below_mask) == '0));
      end
   end
endmodule

// File: rtl/dvs_lru_pick.sv
`timescale 1ns/1ps
// Locates the way whose recency rank is the oldest.
module dvs_lru_pick #(
   parameter int NWAYS = 16,
   parameter int WAYW  = 4
) (
   input  logic [NWAYS*WAYW-1:0] pos_flat,
   output logic                  lru_found,
   output logic [WAYW-1:0]       lru_way
);
   localparam logic [WAYW-1:0] OLDEST = WAYW'(NWAYS - 1);

   logic [NWAYS-1:0] is_oldest;

   for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
      assign is_oldest[w] = (pos_flat[w*WAYW +: WAYW] == OLDEST);
   end

   always_comb begin
      lru_found = 1'b0;
      lru_way   = '0;
      for (int w = 0; w < NWAYS; w++) begin
         if (is_oldest[w]) begin
            lru_found = 1'b1;
            lru_way   = WAYW'(w);
         end
      end
   end
endmodule

// File: rtl/dvs_set_update.sv
`timescale 1ns/1ps
// Next-state of one set: touched way to rank 0, younger ways age by one.
module dvs_set_update #(
   parameter int NWAYS = 16,
   parameter int WAYW  = 4
) (
   input  logic [NWAYS*WAYW-1:0] cur_pos,
   input  logic [NWAYS-1:0]      cur_dead,
   input  logic                  touch_en,
   input  logic [WAYW-1:0]       touch_way,
   input  logic                  new_dead,
   output logic [NWAYS*WAYW-1:0] nxt_pos,
   output logic [NWAYS-1:0]      nxt_dead
);
   logic [WAYW-1:0] touch_rank;

   always_comb begin
      touch_rank = '0;
      for (int w = 0; w < NWAYS; w++) begin
         if (touch_way == WAYW'(w)) touch_rank = cur_pos[w*WAYW +: WAYW];
      end
   end

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      logic [WAYW-1:0] rank;
      logic            sel;
      assign rank = cur_pos[w*WAYW +: WAYW];
      assign sel  = touch_en && (touch_way == WAYW'(w));
      assign nxt_pos[w*WAYW +: WAYW] =
         !touch_en            ? rank :
         sel                  ? '0 :
         (rank < touch_rank)  ? rank + WAYW'(1) : rank;
      assign nxt_dead[w] = sel ? new_dead : cur_dead[w];
   end
endmodule

// File: rtl/dvs_victim_select.sv
`timescale 1ns/1ps
module dvs_victim_select
   import dvs_pkg::*;
#(
   parameter int NWAYS = 16,
   parameter int NSETS = 1024,
   localparam int WAYW = $clog2(NWAYS),
   localparam int SETW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic [SETW-1:0] acc_set,
   input  logic            acc_hit,
   input  logic [WAYW-1:0] acc_hit_way,
   input  logic            acc_dead_pred,
   output logic            fill_bypass,
   output logic            fill_valid,
   output logic [WAYW-1:0] fill_way
);
   localparam int PW = NWAYS * WAYW;

   if (NWAYS < 2 || (NWAYS & (NWAYS - 1)) != 0) begin : g_bad_ways
      $error("NWAYS must be a power of two, at least 2");
   end
   if (NSETS < 1) begin : g_bad_sets
      $error("NSETS must be at least 1");
   end

   // per-set state
   logic [PW-1:0]    pos_mem  [NSETS];
   logic [NWAYS-1:0] dead_mem [NSETS];

   logic [PW-1:0] pos_init;
   for (genvar w = 0; w < NWAYS; w++) begin : g_init
      assign pos_init[w*WAYW +: WAYW] = WAYW'(w);
   end

   logic [PW-1:0]    cur_pos, nxt_pos;
   logic [NWAYS-1:0] cur_dead, nxt_dead;
   assign cur_pos  = pos_mem[acc_set];
   assign cur_dead = dead_mem[acc_set];

   // parallel searches
   logic            dead_found, lru_found;
   logic [WAYW-1:0] dead_way, lru_way, victim;

   dvs_first_set #(.N(NWAYS), .W(WAYW)) u_dead (
      .vec(cur_dead), .found(dead_found), .idx(dead_way));

   dvs_lru_pick #(.NWAYS(NWAYS), .WAYW(WAYW)) u_lru (
      .pos_flat(cur_pos), .lru_found(lru_found), .lru_way(lru_way));

   assign victim = dead_found ? dead_way : lru_way;

   dvs_outcome_e outcome;
   always_comb begin
      if (!acc_valid)         outcome = OUT_IDLE;
      else if (acc_hit)       outcome = OUT_HIT;
      else if (acc_dead_pred) outcome = OUT_BYPASS;
      else                    outcome = OUT_FILL;
   end

   logic            touch_en;
   logic [WAYW-1:0] touch_way;
   assign touch_en  = (outcome == OUT_HIT) || (outcome == OUT_FILL);
   assign touch_way = (outcome == OUT_HIT) ? acc_hit_way : victim;

   dvs_set_update #(.NWAYS(NWAYS), .WAYW(WAYW)) u_upd (
      .cur_pos(cur_pos), .cur_dead(cur_dead),
      .touch_en(touch_en), .touch_way(touch_way), .new_dead(acc_dead_pred),
      .nxt_pos(nxt_pos), .nxt_dead(nxt_dead));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) begin
            pos_mem[s]  <= pos_init;
            dead_mem[s] <= '0;
         end
      end else if (touch_en) begin
         pos_mem[acc_set]  <= nxt_pos;
         dead_mem[acc_set] <= nxt_dead;
      end
   end

   assign fill_bypass = (outcome == OUT_BYPASS);
   assign fill_valid  = (outcome == OUT_FILL);
   assign fill_way    = victim;

   // ---------------- checks ----------------
   function automatic logic [WAYW-1:0] rank_of(input logic [PW-1:0] v,
                                               input logic [WAYW-1:0] way);
      logic [WAYW-1:0] r;
      r = '0;
      for (int w = 0; w < NWAYS; w++) begin
         if (way == WAYW'(w)) r = v[w*WAYW +: WAYW];
      end
      return r;
   endfunction

   logic [NWAYS-1:0] ranks_seen;
   always_comb begin
      ranks_seen = '0;
      for (int w = 0; w < NWAYS; w++) ranks_seen[cur_pos[w*WAYW +: WAYW]] = 1'b1;
   end

   logic             chk_touch, chk_bypass;
   logic [SETW-1:0]  chk_set;
   logic [WAYW-1:0]  chk_way;
   logic [PW-1:0]    chk_pos;
   logic [NWAYS-1:0] chk_dead;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_touch  <= 1'b0;
         chk_bypass <= 1'b0;
         chk_set    <= '0;
         chk_way    <= '0;
         chk_pos    <= '0;
         chk_dead   <= '0;
      end else begin
         chk_touch  <= touch_en;
         chk_bypass <= fill_bypass;
         chk_set    <= acc_set;
         chk_way    <= touch_way;
         chk_pos    <= cur_pos;
         chk_dead   <= cur_dead;
      end
   end

   a_r7_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (ranks_seen == '1 && lru_found));

   a_r2_touched_is_mru: assert property (@(posedge clk) disable iff (!rst_n)
      chk_touch |-> (rank_of(pos_mem[chk_set], chk_way) == '0));

   a_r4_bypass_keeps_set: assert property (@(posedge clk) disable iff (!rst_n)
      chk_bypass |-> (pos_mem[chk_set] == chk_pos && dead_mem[chk_set] == chk_dead));

   a_r4_bypass_excludes_fill: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_bypass && fill_valid));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!fill_bypass && !fill_valid));

   a_r6_clean_set_takes_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && cur_dead == '0) |-> (rank_of(cur_pos, fill_way) == WAYW'(NWAYS - 1)));
endmodule

// File: tb/tb_dvs_victim_select.sv
`timescale 1ns/1ps
module tb_dvs_victim_select;
   localparam int NW = 16;
   localparam int NS = 8;
   localparam int WW = 4;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [SW-1:0] acc_set = '0;
   logic          acc_hit = 1'b0;
   logic [WW-1:0] acc_hit_way = '0;
   logic          acc_dead_pred = 1'b0;
   logic          fill_bypass, fill_valid;
   logic [WW-1:0] fill_way;

   dvs_victim_select #(.NWAYS(NW), .NSETS(NS)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_dead_pred(acc_dead_pred),
      .fill_bypass(fill_bypass), .fill_valid(fill_valid), .fill_way(fill_way));

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int mrank [NS][NW];
   bit mdead [NS][NW];

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_victim(int s);
      for (int w = 0; w < NW; w++) if (mdead[s][w]) return w;
      for (int w = 0; w < NW; w++) if (mrank[s][w] == NW - 1) return w;
      return -1;
   endfunction

   function automatic void touch(int s, int way, bit pred);
      int p = mrank[s][way];
      for (int w = 0; w < NW; w++) if (mrank[s][w] < p) mrank[s][w]++;
      mrank[s][way] = 0;
      mdead[s][way] = pred;
   endfunction

   // one request: drive at negedge, check before the next posedge
   task automatic access(bit v, int s, bit hit, int way, bit pred, string req);
      int ev;
      @(negedge clk);
      acc_valid = v; acc_set = SW'(s); acc_hit = hit;
      acc_hit_way = WW'(way); acc_dead_pred = pred;
      #1;
      ev = exp_victim(s);
      check({req, " bypass"}, int'(fill_bypass), int'(v && !hit && pred));
      check({req, " valid"}, int'(fill_valid), int'(v && !hit && !pred));
      if (v && !hit && !pred) check({req, " way"}, int'(fill_way), ev);
      if (v && hit) touch(s, way, pred);
      else if (v && !pred) touch(s, ev, pred);
   endtask

   initial begin
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin mrank[s][w] = w; mdead[s][w] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: fresh sets give the last way; R4 bypass first leaves it intact
      access(1, 0, 0, 0, 1, "R4");
      access(1, 0, 0, 0, 0, "R1");
      access(1, 2, 0, 0, 0, "R1");
      // R9: idle request
      access(0, 0, 0, 0, 0, "R9");
      // R2/R3: hits mark ways 9 and 3 dead, both MRU
      access(1, 1, 1, 9, 1, "R2");
      access(1, 1, 1, 3, 1, "R3");
      // R5: lowest dead way beats the oldest
      access(1, 1, 0, 0, 0, "R5");
      access(1, 1, 0, 0, 0, "R5");
      // R3: clear a dead bit by hit, then clean miss falls back to rank
      access(1, 1, 1, 5, 1, "R3");
      access(1, 1, 1, 5, 0, "R3");
      access(1, 1, 0, 0, 0, "R6");
      // R7: sweep of hits then successive fills expose the order
      for (int w = 0; w < NW; w++) access(1, 4, 1, (w * 7) % NW, 0, "R7");
      for (int k = 0; k < NW + 2; k++) access(1, 4, 0, 0, 0, "R7");
      // R4: bypass in a set with dead lines changes nothing
      access(1, 5, 1, 12, 1, "R4");
      access(1, 5, 0, 0, 1, "R4");
      access(1, 5, 0, 0, 0, "R5");
      // R8: heavy traffic on set 6, then set 7 still fresh
      for (int k = 0; k < 20; k++) access(1, 6, k % 3 == 0, k % NW, k % 5 == 0, "R8");
      access(1, 7, 0, 0, 0, "R8");
      // random mix over all sets
      for (int k = 0; k < 4000; k++) begin
         int r = $urandom;
         access((r & 15) != 0, (r >> 4) % NS, ((r >> 8) & 1) == 1,
                (r >> 9) % NW, ((r >> 13) & 3) == 0, "R7");
      end
      access(0, 0, 0, 0, 0, "R9");
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule